// File: doc/BRIEF.md
# External Bus Strobe Sequencer

This block times the external memory bus of a small 8-bit controller. It splits every machine cycle into two equal halves and, in each half, raises an address-latch strobe at the start and then may pull a program-store strobe low. When the core asks for an external data read or write, the block runs a data cycle instead. In a data cycle the second address-latch pulse and both program-store pulses are dropped, and a read or write strobe spans their slots.

A double-speed select halves the machine cycle. A latch-inhibit bit silences the address-latch strobe during internal code fetches. The high address byte comes from the code address during fetches. During data cycles it comes from the data pointer for wide (16-bit) accesses and from the port 2 latch for narrow (8-bit) ones. The multiplexed low byte carries the address while the latch strobe is high and write data while the write strobe is low.

Every input that shapes a machine cycle is captured on the clock edge that starts that cycle. A core can therefore set up the next request while the current cycle is still running.

Top module: `extbus_strobe_seq`

## Requirements
- R1: A machine cycle lasts 2×HALF_CLKS clocks (12 by default) in standard mode and HALF_CLKS clocks (6) when `dblSpeed` is 1. It consists of two equal halves of H clocks, and tick k counts 0..H-1 within each half.
- R2: In a fetch cycle that is not inhibited, `ale` is high for ticks k < H/3 of both halves, which is two pulses per machine cycle. Those ticks are 0–1 in standard mode and tick 0 in double-speed mode.
- R3: In a fetch cycle with `extFetch`=1, `psenN` is low for ticks k ≥ H/2 of both halves. With `extFetch`=0 it stays high for the whole cycle. `ale` and `psenN` are never active together.
- R4: With `aleInhibit`=1, `ale` stays low throughout an internal fetch cycle. An external fetch cycle still pulses `ale` as in R2.
- R5: A machine cycle that starts with `reqValid`=1 is a data cycle. In a data cycle, `ale` pulses only in the first half and `psenN` stays high. The strobe selected by `reqWrite` (1 selects `wrN`, 0 selects `rdN`) is low from tick H/2 of the first half to the end of the cycle, regardless of `aleInhibit`.
- R6: `rdN` and `wrN` are never low together, and neither is low while `psenN` is low.
- R7: `addrHigh` carries `codeAddr[15:8]` in a fetch cycle. In a data cycle it carries `dataPtr[15:8]` when `reqWide`=1 and `port2Latch` when `reqWide`=0.
- R8: While `ale` is high, `adLow` carries the low address byte: `codeAddr[7:0]`, `dataPtr[7:0]` or `riAddr`, chosen as in R7. While `wrN` is low it carries `wrData`. Otherwise it is FFh.
- R9: While `rst` is high, `ale` is 0, `psenN`, `rdN` and `wrN` are 1, and both address bytes are FFh. The first clock edge with `rst` low starts a machine cycle at tick 0 of the first half.
- R10: `dblSpeed`, `extFetch`, `aleInhibit`, the request inputs, the addresses and `wrData` are sampled only on the edge that starts a machine cycle. Changing them later in that cycle has no effect on its outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous reset, active high |
| dblSpeed | input | 1 | 1 selects the half-length machine cycle |
| extFetch | input | 1 | Code fetch of this cycle is from external memory |
| aleInhibit | input | 1 | Suppresses the latch strobe during internal fetches |
| reqValid | input | 1 | External data access requested |
| reqWrite | input | 1 | Data access is a write (else read) |
| reqWide | input | 1 | Data access uses a 16-bit address |
| codeAddr | input | 16 | Program fetch address |
| dataPtr | input | 16 | Data pointer for wide accesses |
| riAddr | input | 8 | Address for narrow accesses |
| port2Latch | input | 8 | Port 2 latch value, high byte for narrow accesses |
| wrData | input | 8 | Data byte for writes |
| ale | output | 1 | Address latch strobe, active high |
| psenN | output | 1 | Program store strobe, active low |
| rdN | output | 1 | Data read strobe, active low |
| wrN | output | 1 | Data write strobe, active low |
| adLow | output | 8 | Multiplexed low address / data byte |
| addrHigh | output | 8 | High address byte |

## Verification
The bench uses the default HALF_CLKS=6 and BYTE_W=8. That gives six-clock halves in standard mode and three-clock halves in double-speed mode, so every tick position of both cycle lengths can be checked directly. Both speeds are swept against all eight access types: internal and external fetch with the inhibit bit clear and set, and reads and writes with narrow and wide addressing. Each type runs with several address patterns. All inputs are inverted one clock into each cycle to show that the captured values rule. A reset between cycles shows that the sequence restarts cleanly.

// File: rtl/extbus_pkg.sv
package extbus_pkg;

  typedef enum logic [1:0] {
    CYC_IDLE  = 2'd0,
    CYC_FETCH = 2'd1,
    CYC_READ  = 2'd2,
    CYC_WRITE = 2'd3
  } cycKind_t;

  // Active-high strobes from control to datapath.
  typedef struct packed {
    logic load;   // this edge starts a machine cycle
    logic ale;
    logic psen;
    logic rd;
    logic wr;
  } busStrobes_t;

endpackage

// File: rtl/extbus_ctrl.sv
module extbus_ctrl
  import extbus_pkg::*;
#(
  parameter int HALF_CLKS = 6   // clocks per half machine cycle, multiple of 6
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        dblSpeed,
  input  logic        extFetch,
  input  logic        aleInhibit,
  input  logic        reqValid,
  input  logic        reqWrite,
  output busStrobes_t strb
);

  localparam int TW = $clog2(HALF_CLKS + 1);
  localparam logic [TW-1:0] HALF_SLOW = TW'(HALF_CLKS);
  localparam logic [TW-1:0] HALF_FAST = TW'(HALF_CLKS / 2);
  localparam logic [TW-1:0] ALE_SLOW  = TW'(HALF_CLKS / 3);
  localparam logic [TW-1:0] ALE_FAST  = TW'((HALF_CLKS / 2) / 3);
  localparam logic [TW-1:0] STB_SLOW  = TW'(HALF_CLKS / 2);
  localparam logic [TW-1:0] STB_FAST  = TW'((HALF_CLKS / 2) / 2);

  logic [TW-1:0] tick;
  logic          half;
  cycKind_t      kind;
  logic          dblQ, extQ, inhQ;

  logic [TW-1:0] halfLen, aleLim, stbStart;
  logic          lastTick, start, isData, isFetch, aleWin, stbWin, xfer;

  always_comb begin
    halfLen  = dblQ ? HALF_FAST : HALF_SLOW;
    aleLim   = dblQ ? ALE_FAST  : ALE_SLOW;
    stbStart = dblQ ? STB_FAST  : STB_SLOW;
    lastTick = (tick == halfLen - TW'(1));
    start    = (kind == CYC_IDLE) || (lastTick && half);
    isFetch  = (kind == CYC_FETCH);
    isData   = (kind == CYC_READ) || (kind == CYC_WRITE);
    aleWin   = (tick < aleLim);
    stbWin   = (tick >= stbStart);
    xfer     = isData && (half || stbWin);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tick <= '0;
      half <= 1'b0;
      kind <= CYC_IDLE;
      dblQ <= 1'b0;
      extQ <= 1'b0;
      inhQ <= 1'b0;
    end else if (start) begin
      tick <= '0;
      half <= 1'b0;
      kind <= reqValid ? (reqWrite ? CYC_WRITE : CYC_READ) : CYC_FETCH;
      dblQ <= dblSpeed;
      extQ <= extFetch;
      inhQ <= aleInhibit;
    end else if (lastTick) begin
      tick <= '0;
      half <= 1'b1;
    end else begin
      tick <= tick + TW'(1);
    end
  end

  always_comb begin
    strb.load = start;
    strb.ale  = aleWin && ((isFetch && (extQ || !inhQ)) || (isData && !half));
    strb.psen = isFetch && extQ && stbWin;
    strb.rd   = xfer && (kind == CYC_READ);
    strb.wr   = xfer && (kind == CYC_WRITE);
  end

endmodule

// File: rtl/extbus_datapath.sv
module extbus_datapath
  import extbus_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  busStrobes_t       strb,
  input  logic              reqValid,
  input  logic              reqWide,
  input  logic [2*BYTE_W-1:0] codeAddr,
  input  logic [2*BYTE_W-1:0] dataPtr,
  input  logic [BYTE_W-1:0] riAddr,
  input  logic [BYTE_W-1:0] port2Latch,
  input  logic [BYTE_W-1:0] wrData,
  output logic              ale,
  output logic              psenN,
  output logic              rdN,
  output logic              wrN,
  output logic [BYTE_W-1:0] adLow,
  output logic [BYTE_W-1:0] addrHigh
);

  logic [BYTE_W-1:0] hiQ, loQ, wdQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      hiQ <= '1;
      loQ <= '1;
      wdQ <= '1;
    end else if (strb.load) begin
      wdQ <= wrData;
      if (!reqValid) begin
        hiQ <= codeAddr[2*BYTE_W-1:BYTE_W];
        loQ <= codeAddr[BYTE_W-1:0];
      end else if (reqWide) begin
        hiQ <= dataPtr[2*BYTE_W-1:BYTE_W];
        loQ <= dataPtr[BYTE_W-1:0];
      end else begin
        hiQ <= port2Latch;
        loQ <= riAddr;
      end
    end
  end

  always_comb begin
    ale      = strb.ale;
    psenN    = ~strb.psen;
    rdN      = ~strb.rd;
    wrN      = ~strb.wr;
    addrHigh = hiQ;
    if (strb.ale)     adLow = loQ;
    else if (strb.wr) adLow = wdQ;
    else              adLow = '1;
  end

endmodule

// File: rtl/extbus_strobe_seq.sv
module extbus_strobe_seq
  import extbus_pkg::*;
#(
  parameter int HALF_CLKS = 6,
  parameter int BYTE_W    = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                dblSpeed,
  input  logic                extFetch,
  input  logic                aleInhibit,
  input  logic                reqValid,
  input  logic                reqWrite,
  input  logic                reqWide,
  input  logic [2*BYTE_W-1:0] codeAddr,
  input  logic [2*BYTE_W-1:0] dataPtr,
  input  logic [BYTE_W-1:0]   riAddr,
  input  logic [BYTE_W-1:0]   port2Latch,
  input  logic [BYTE_W-1:0]   wrData,
  output logic                ale,
  output logic                psenN,
  output logic                rdN,
  output logic                wrN,
  output logic [BYTE_W-1:0]   adLow,
  output logic [BYTE_W-1:0]   addrHigh
);

  busStrobes_t strb;

  extbus_ctrl #(.HALF_CLKS(HALF_CLKS)) u_ctrl (
    .clk(clk), .rst(rst), .dblSpeed(dblSpeed), .extFetch(extFetch),
    .aleInhibit(aleInhibit), .reqValid(reqValid), .reqWrite(reqWrite),
    .strb(strb)
  );

  extbus_datapath #(.BYTE_W(BYTE_W)) u_dp (
    .clk(clk), .rst(rst), .strb(strb), .reqValid(reqValid), .reqWide(reqWide),
    .codeAddr(codeAddr), .dataPtr(dataPtr), .riAddr(riAddr),
    .port2Latch(port2Latch), .wrData(wrData),
    .ale(ale), .psenN(psenN), .rdN(rdN), .wrN(wrN),
    .adLow(adLow), .addrHigh(addrHigh)
  );

endmodule

// File: rtl/extbus_checker.sv
module extbus_checker (
  input logic clk,
  input logic rst,
  input logic ale,
  input logic psenN,
  input logic rdN,
  input logic wrN
);

  assert_rd_wr_excl_R6: assert property (@(posedge clk) disable iff (rst)
    !(!rdN && !wrN));

  assert_psen_xfer_excl_R6: assert property (@(posedge clk) disable iff (rst)
    !(!psenN && (!rdN || !wrN)));

  assert_ale_psen_apart_R3: assert property (@(posedge clk) disable iff (rst)
    !(ale && !psenN));

  assert_ale_xfer_apart_R5: assert property (@(posedge clk) disable iff (rst)
    !(ale && (!rdN || !wrN)));

  assert_reset_quiet_R9: assert property (@(posedge clk)
    rst |=> (!ale && psenN && rdN && wrN));

endmodule

bind extbus_strobe_seq extbus_checker u_chk (
  .clk(clk), .rst(rst), .ale(ale), .psenN(psenN), .rdN(rdN), .wrN(wrN)
);

// File: tb/extbus_strobe_seq_bench.sv
module extbus_strobe_seq_bench;

  localparam int HALF = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic dblSpeed = 0, extFetch = 0, aleInhibit = 0;
  logic reqValid = 0, reqWrite = 0, reqWide = 0;
  logic [15:0] codeAddr = 16'h0, dataPtr = 16'h0;
  logic [7:0]  riAddr = 8'h0, port2Latch = 8'h0, wrData = 8'h0;
  logic ale, psenN, rdN, wrN;
  logic [7:0] adLow, addrHigh;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  extbus_strobe_seq u_extbus_strobe_seq (
    .clk(clk), .rst(rst), .dblSpeed(dblSpeed), .extFetch(extFetch),
    .aleInhibit(aleInhibit), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqWide(reqWide), .codeAddr(codeAddr), .dataPtr(dataPtr),
    .riAddr(riAddr), .port2Latch(port2Latch), .wrData(wrData),
    .ale(ale), .psenN(psenN), .rdN(rdN), .wrN(wrN),
    .adLow(adLow), .addrHigh(addrHigh)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s t=%0t actual=%0h expected=%0h", tag, $time, act, exp);
    end
  endtask

  task automatic checkQuiet();
    chk("R9 ale", int'(ale), 0);
    chk("R9 psenN", int'(psenN), 1);
    chk("R9 rdN", int'(rdN), 1);
    chk("R9 wrN", int'(wrN), 1);
    chk("R9 addrHigh", int'(addrHigh), 8'hFF);
    chk("R9 adLow", int'(adLow), 8'hFF);
  endtask

  // Inputs are applied at a negedge; the following posedge starts the cycle.
  task automatic runCycle(input logic d, input logic e, input logic inh,
                          input logic rq, input logic w, input logic wd,
                          input logic [15:0] ca, input logic [15:0] dp,
                          input logic [7:0] ri, input logic [7:0] p2,
                          input logic [7:0] wdat);
    int hl, aw, ps, hf, k;
    logic expAle, expPsen, expXfer;
    logic [7:0] hi, lo, expAd;
    string aTag;
    dblSpeed = d; extFetch = e; aleInhibit = inh;
    reqValid = rq; reqWrite = w; reqWide = wd;
    codeAddr = ca; dataPtr = dp; riAddr = ri; port2Latch = p2; wrData = wdat;
    hl = d ? HALF / 2 : HALF;
    aw = hl / 3;
    ps = hl / 2;
    hi = rq ? (wd ? dp[15:8] : p2) : ca[15:8];
    lo = rq ? (wd ? dp[7:0] : ri) : ca[7:0];
    for (int t = 0; t < 2 * hl; t++) begin
      @(negedge clk);
      hf = t / hl;
      k  = t % hl;
      if (!rq) begin
        expAle  = (k < aw) && (e || !inh);
        expPsen = e && (k >= ps);
        expXfer = 1'b0;
      end else begin
        expAle  = (k < aw) && (hf == 0);
        expPsen = 1'b0;
        expXfer = (hf == 1) || (k >= ps);
      end
      if (t == 0 && !rq && (e || !inh)) aTag = "R1 ale at cycle start";
      else if (rq)                      aTag = "R5 ale";
      else if (inh && !e)               aTag = "R4 ale";
      else                              aTag = "R2 ale";
      chk(aTag, int'(ale), int'(expAle));
      chk(rq ? "R5 psenN" : "R3 psenN", int'(psenN), int'(!expPsen));
      chk("R5 rdN", int'(rdN), int'(!(expXfer && !w)));
      chk("R5 wrN", int'(wrN), int'(!(expXfer && w)));
      chk("R6 exclusive", int'((!psenN && (!rdN || !wrN)) || (!rdN && !wrN)), 0);
      chk(t >= 2 ? "R10 addrHigh" : "R7 addrHigh", int'(addrHigh), int'(hi));
      expAd = expAle ? lo : ((expXfer && w) ? wdat : 8'hFF);
      chk(t >= 2 ? "R10 adLow" : "R8 adLow", int'(adLow), int'(expAd));
      if (t == 1) begin
        dblSpeed = ~d; extFetch = ~e; aleInhibit = ~inh;
        reqValid = ~rq; reqWrite = ~w; reqWide = ~wd;
        codeAddr = ~ca; dataPtr = ~dp; riAddr = ~ri; port2Latch = ~p2; wrData = ~wdat;
      end
    end
  endtask

  task automatic sweep(input int rep);
    for (int d = 0; d < 2; d++) begin
      for (int m = 0; m < 8; m++) begin
        logic rq, inh, e, w, wd;
        logic [15:0] base;
        rq   = m[2];
        inh  = m[0];
        e    = rq ? 1'b0 : m[1];
        w    = rq ? m[1] : 1'b0;
        wd   = m[0];
        base = 16'h1234 + 16'(rep * 16'h2F1B + d * 16'h0808 + m * 16'h0111);
        runCycle(d[0], e, inh, rq, w, wd, base, base ^ 16'hA55A,
                 base[7:0] ^ 8'h3C, base[15:8] ^ 8'hC3, base[7:0] + 8'h71);
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    checkQuiet();   // R9 reset state
    rst = 1'b0;
    for (int rep = 0; rep < 3; rep++) sweep(rep);
    // Reset between cycles, then restart from tick 0 (R9)
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    checkQuiet();
    rst = 1'b0;
    runCycle(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 16'hBEEF, 16'h0, 8'h0, 8'h0, 8'h0);
    runCycle(1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 16'h0, 16'hC0DE, 8'h11, 8'h22, 8'h5A);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule